// File: doc/BRIEF.md
# Interrupt Output Controller with Deassertion Holdoff

This block merges a vector of internal interrupt sources, each qualified by its own enable bit, into one external interrupt request line. Once the line's request drops, the block can hold the pin quiet for a programmable holdoff window. The window is counted in 10 µs steps that a prescaler derives from the system clock. While the window runs, enabled sources cannot reach the pin. A separate wake-event input is exempt from the window and always reaches the pin.

Software uses a single 32-bit configuration register, written through a plain write strobe and read back continuously. Through it, software sets the holdoff length, restarts or cancels a running window, gates the pin, and picks the output stage. The pin is driven as a data/output-enable pair, which models both a push-pull driver and an open-drain wired-OR driver. An internal master interrupt bit tracks the enabled sources directly, whatever the gating and the holdoff do.

Top module: `irq_line_ctrl`

## Requirements
- R1: Register bit 12 (master) reads 1 exactly when some source has both its status bit and its enable bit set. It ignores the holdoff window, the wake input and the output gate.
- R2: Reset clears the register to all zeros. A write stores bits 31:24 (holdoff length), bit 8 (output gate), bit 4 (active level) and bit 0 (driver kind), and these read back unchanged. Every other stored bit reads 0.
- R3: A holdoff window starts on the clock edge at which the pin request falls from 1 to 0 while no window is running. The counter loads the stored length L and counts down once every CLK_HZ/100000 cycles. The window ends after L×CLK_HZ/100000 cycles. Bit 13 reads 1 for exactly the duration of the window.
- R4: While a window runs, enabled sources do not assert the pin. A source that is still active when the window ends asserts the pin on the next edge.
- R5: Writing 1 to bit 14 reloads the window from the length being written, whether or not a window is running. Bit 14 always reads 0.
- R6: Writing a length of 0 clears the counter at once and ends any running window. A source held back by that window reaches the pin one cycle after the write.
- R7: Writing a new non-zero length without bit 14 leaves a running window unchanged. The new length applies to the next window.
- R8: A wake-event input that is high on an edge asserts the pin after that edge, even while a window runs.
- R9: With bit 8 at 0 the pin is never asserted, while bits 12 and 13 keep working.
- R10: With bit 0 at 1 (push-pull), irq_oe is always 1. irq_o equals the request when bit 4 is 1 (active high) and the inverted request when bit 4 is 0 (active low).
- R11: With bit 0 at 0 (open-drain), irq_o is always 0, irq_oe is 1 only while the line is asserted, and bit 4 has no effect.
- R12: The pin request is registered. A change in sources or wake appears on the pin one clock edge later, and an output gate or driver-kind change applies in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register readback, including live status bits |
| src_status | input | N_SRC | Raw interrupt status, one bit per source |
| src_enable | input | N_SRC | Per-source enable mask |
| wake_evt | input | 1 | Wake event, exempt from the holdoff window |
| irq_o | output | 1 | Pin data value |
| irq_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach from the ports is a software action that lands inside a running holdoff window while a source is still pending. Examples are a restart, a zero-length cancel, or a length change, each of which must move the release edge to a specific cycle. The bench scales CLK_HZ so that one holdoff step is ten cycles. It drops a source to open a window, re-raises it so that a request is pending, and then issues each write at a chosen cycle count into the window. Random traffic then mixes short lengths, restarts, wake pulses and driver-mode changes against a cycle-level model.

// File: rtl/irq_line_pkg.sv
`timescale 1ns/1ps
package irq_line_pkg;
  localparam int IVL_W      = 8;
  localparam int IVL_LSB    = 24;
  localparam int CLR_BIT    = 14;
  localparam int BUSY_BIT   = 13;
  localparam int MASTER_BIT = 12;
  localparam int EN_BIT     = 8;
  localparam int POL_BIT    = 4;
  localparam int KIND_BIT   = 0;
  localparam int TICK_HZ    = 100_000;

  typedef enum logic {
    DRV_OPEN_DRAIN = 1'b0,
    DRV_PUSH_PULL  = 1'b1
  } drv_kind_e;

  typedef struct packed {
    logic [IVL_W-1:0] ivl;
    logic             out_en;
    logic             act_high;
    drv_kind_e        kind;
  } line_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import irq_line_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic             busy,
  input  logic             master,
  output line_cfg_t        cfg,
  output logic [31:0]      rdata,
  output logic             kill,
  output logic             restart,
  output logic [IVL_W-1:0] new_ivl
);
  logic [IVL_W-1:0] wr_ivl;
  logic             wdata_unused;

  assign wr_ivl = wdata[IVL_LSB +: IVL_W];
  assign wdata_unused = ^{wdata[IVL_LSB-1:CLR_BIT+1], wdata[BUSY_BIT:EN_BIT+1],
                          wdata[EN_BIT-1:POL_BIT+1], wdata[POL_BIT-1:KIND_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{ivl: '0, out_en: 1'b0, act_high: 1'b0, kind: DRV_OPEN_DRAIN};
    end else if (wr_en) begin
      cfg.ivl      <= wr_ivl;
      cfg.out_en   <= wdata[EN_BIT];
      cfg.act_high <= wdata[POL_BIT];
      cfg.kind     <= drv_kind_e'(wdata[KIND_BIT]);
    end
  end

  // zero-length write wins over restart; restart loads the value being written
  assign kill    = wr_en && (wr_ivl == '0);
  assign restart = wr_en && wdata[CLR_BIT];
  assign new_ivl = wr_ivl;

  always_comb begin
    rdata                     = '0;
    rdata[IVL_LSB +: IVL_W]   = cfg.ivl;
    rdata[BUSY_BIT]           = busy;
    rdata[MASTER_BIT]         = master;
    rdata[EN_BIT]             = cfg.out_en;
    rdata[POL_BIT]            = cfg.act_high;
    rdata[KIND_BIT]           = cfg.kind;
  end
endmodule

// File: rtl/irq_tick_gen.sv
`timescale 1ns/1ps
module irq_tick_gen #(
  parameter int DIV = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (run)     pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      end

      assign tick = run && !restart && (pre_q == LAST);
    end else begin : g_nodiv
      assign tick = run && !restart;
    end
  endgenerate
endmodule

// File: rtl/irq_holdoff_timer.sv
`timescale 1ns/1ps
module irq_holdoff_timer
  import irq_line_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             restart,
  input  logic [IVL_W-1:0] restart_ivl,
  input  logic             fall,
  input  logic [IVL_W-1:0] cfg_ivl,
  input  logic             tick,
  output logic             busy,
  output logic             load
);
  logic [IVL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (kill)                 cnt_q <= '0;
    else if (restart)              cnt_q <= restart_ivl;
    else if (fall)                 cnt_q <= cfg_ivl;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign load = kill || restart || fall;
endmodule

// File: rtl/irq_out_stage.sv
`timescale 1ns/1ps
module irq_out_stage
  import irq_line_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_status,
  input  logic [N_SRC-1:0] src_enable,
  input  logic             wake,
  input  logic             busy,
  input  line_cfg_t        cfg,
  output logic             master,
  output logic             fall,
  output logic             irq_o,
  output logic             irq_oe
);
  logic req, req_q, drive;

  assign master = |(src_status & src_enable);
  assign req    = (master && !busy) || wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  // a window opens only from idle, so a restart that blocks the request does not reload
  assign fall  = req_q && !req && !busy;
  assign drive = req_q && cfg.out_en;

  always_comb begin
    unique case (cfg.kind)
      DRV_PUSH_PULL: begin
        irq_oe = 1'b1;
        irq_o  = cfg.act_high ? drive : !drive;
      end
      default: begin
        irq_oe = drive;
        irq_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/irq_line_ctrl.sv
`timescale 1ns/1ps
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int CLK_HZ = 200_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [N_SRC-1:0] src_status,
  input  logic [N_SRC-1:0] src_enable,
  input  logic             wake_evt,
  output logic             irq_o,
  output logic             irq_oe
);
  localparam int TICK_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  line_cfg_t        cfg;
  logic             busy, master, fall, tick, load, kill, restart;
  logic [IVL_W-1:0] new_ivl;

  irq_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .busy(busy), .master(master), .cfg(cfg), .rdata(reg_rdata),
    .kill(kill), .restart(restart), .new_ivl(new_ivl)
  );

  irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(load), .run(busy), .tick(tick)
  );

  irq_holdoff_timer u_hold (
    .clk(clk), .rst_n(rst_n), .kill(kill), .restart(restart),
    .restart_ivl(new_ivl), .fall(fall), .cfg_ivl(cfg.ivl), .tick(tick),
    .busy(busy), .load(load)
  );

  irq_out_stage #(.N_SRC(N_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .src_status(src_status), .src_enable(src_enable),
    .wake(wake_evt), .busy(busy), .cfg(cfg), .master(master), .fall(fall),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );
endmodule

// File: rtl/irq_line_ctrl_chk.sv
`timescale 1ns/1ps
module irq_line_ctrl_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic [N_SRC-1:0] src_status,
  input logic [N_SRC-1:0] src_enable,
  input logic             wake_evt,
  input logic             irq_o,
  input logic             irq_oe
);
  logic asrt;
  assign asrt = reg_rdata[0] ? (irq_oe && (irq_o == reg_rdata[4])) : irq_oe;

  AST_MASTER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[12] == |(src_status & src_enable)); // R1
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[14]); // R5
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    asrt |-> ($past(wake_evt) || ($past(reg_rdata[12]) && !$past(reg_rdata[13])))); // R4
  AST_WAKE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake_evt) && reg_rdata[8]) |-> asrt); // R8
  AST_ZERO_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr_en && (reg_wdata[31:24] == 8'd0)) |-> !reg_rdata[13]); // R6
  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[8] |-> !asrt); // R9
  AST_PP_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] |-> irq_oe); // R10
  AST_OD_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0] |-> !irq_o); // R11
endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .src_status(src_status), .src_enable(src_enable),
  .wake_evt(wake_evt), .irq_o(irq_o), .irq_oe(irq_oe)
);

// File: tb/irq_line_ctrl_tb.sv
`timescale 1ns/1ps
module irq_line_ctrl_tb;
  localparam int N      = 8;
  localparam int CLK_HZ = 1_000_000; // scaled so one holdoff step is 10 cycles
  localparam int DIV    = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  src_status = '0;
  logic [N-1:0]  src_enable = '0;
  logic          wake_evt = 1'b0;
  logic          irq_o, irq_oe;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  irq_line_ctrl #(.N_SRC(N), .CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_status(src_status), .src_enable(src_enable),
    .wake_evt(wake_evt), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // cycle-level reference model built from the requirements
  logic [7:0] m_ivl, m_cnt;
  logic       m_en, m_pol, m_kind, m_req_q;
  int         m_pre;

  always @(posedge clk or negedge rst_n) begin
    logic mm, mb, rq;
    if (!rst_n) begin
      m_ivl <= '0; m_cnt <= '0; m_en <= 0; m_pol <= 0; m_kind <= 0;
      m_req_q <= 0; m_pre <= 0;
    end else begin
      mm = |(src_status & src_enable);
      mb = (m_cnt != 0);
      rq = (mm && !mb) || wake_evt;
      m_req_q <= rq;
      if (reg_wr_en && reg_wdata[31:24] == 8'd0) begin
        m_cnt <= '0; m_pre <= 0;
      end else if (reg_wr_en && reg_wdata[14]) begin
        m_cnt <= reg_wdata[31:24]; m_pre <= 0;
      end else if (m_req_q && !rq && !mb) begin
        m_cnt <= m_ivl; m_pre <= 0;
      end else if (mb) begin
        if (m_pre == DIV - 1) begin m_pre <= 0; m_cnt <= m_cnt - 8'd1; end
        else m_pre <= m_pre + 1;
      end
      if (reg_wr_en) begin
        m_ivl <= reg_wdata[31:24]; m_en <= reg_wdata[8];
        m_pol <= reg_wdata[4];     m_kind <= reg_wdata[0];
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    return {m_ivl, 10'b0, (m_cnt != 0), |(src_status & src_enable),
            3'b0, m_en, 3'b0, m_pol, 3'b0, m_kind};
  endfunction

  function automatic logic [1:0] exp_pin(); // {oe, o}
    logic drv;
    drv = m_req_q && m_en;
    if (m_kind) return {1'b1, m_pol ? drv : !drv};
    return {drv, 1'b0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    check({tag, " rdata"}, reg_rdata, exp_rdata());
    check({tag, " pin"}, {30'b0, irq_oe, irq_o}, {30'b0, exp_pin()});
  endtask

  task automatic step(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk_all(tag);
    end
  endtask

  task automatic wr(logic [31:0] d, string tag);
    reg_wr_en = 1'b1; reg_wdata = d;
    step(1, tag);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: all requirements, actual hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    check("R2 reset rdata", reg_rdata, 32'h0);
    check("R11 reset oe idle", {31'b0, irq_oe}, 32'h0);

    wr(32'h0300_0111, "R2 write");
    check("R2 readback", reg_rdata, 32'h0300_0111);
    src_enable = 8'h01; src_status = 8'h01;
    step(1, "R12 latency");
    check("R10 active high asserted", {31'b0, irq_o}, 32'h1);

    src_status = 8'h00;
    step(1, "R3 window start");
    check("R3 busy set", {31'b0, reg_rdata[13]}, 32'h1);
    src_status = 8'h01;
    step(5, "R4 held");
    check("R4 pin blocked", {31'b0, irq_o}, 32'h0);
    check("R1 master ignores hold", {31'b0, reg_rdata[12]}, 32'h1);
    step(30, "R3 R4 window");
    check("R4 released", {31'b0, irq_o}, 32'h1);
    check("R3 window over", {31'b0, reg_rdata[13]}, 32'h0);

    src_status = 8'h00;
    step(1, "R8 open window");
    wake_evt = 1'b1;
    step(1, "R8 wake");
    check("R8 wake passes hold", {31'b0, irq_o}, 32'h1);
    wake_evt = 1'b0;
    step(15, "R5 mid window");
    wr(32'h0300_4111, "R5 restart");
    check("R5 clear reads zero", {31'b0, reg_rdata[14]}, 32'h0);
    step(25, "R5 restarted");
    check("R5 still busy after restart", {31'b0, reg_rdata[13]}, 32'h1);
    step(10, "R5 end");
    check("R5 window ends", {31'b0, reg_rdata[13]}, 32'h0);

    src_status = 8'h01;
    step(2, "R6 setup");
    src_status = 8'h00;
    step(1, "R6 open");
    src_status = 8'h01;
    step(3, "R6 pending");
    wr(32'h0000_0111, "R6 cancel");
    check("R6 busy cleared", {31'b0, reg_rdata[13]}, 32'h0);
    step(1, "R6 release");
    check("R6 pending delivered", {31'b0, irq_o}, 32'h1);

    wr(32'h0400_0111, "R7 len4");
    src_status = 8'h00;
    step(5, "R7 open");
    wr(32'h0100_0111, "R7 len1");
    step(20, "R7 running");
    check("R7 old length kept", {31'b0, reg_rdata[13]}, 32'h1);
    step(20, "R7 done");
    src_status = 8'h01;
    step(2, "R7 assert");
    src_status = 8'h00;
    step(5, "R7 new window");
    check("R7 new window busy", {31'b0, reg_rdata[13]}, 32'h1);
    step(8, "R7 short");
    check("R7 new length used", {31'b0, reg_rdata[13]}, 32'h0);

    src_status = 8'h01;
    wr(32'h0100_0011, "R9 gate off");
    step(2, "R9 quiet");
    check("R9 pin deasserted", {30'b0, irq_oe, irq_o}, 32'h2);
    check("R1 master with gate off", {31'b0, reg_rdata[12]}, 32'h1);
    wr(32'h0100_0101, "R10 active low");
    step(1, "R10");
    check("R10 active low asserted", {30'b0, irq_oe, irq_o}, 32'h2);
    wr(32'h0100_0110, "R11 open drain");
    check("R11 od asserted ignores polarity", {30'b0, irq_oe, irq_o}, 32'h2);
    src_status = 8'h00;
    step(1, "R11 release");
    check("R11 od released", {30'b0, irq_oe, irq_o}, 32'h0);

    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 8 == 0) src_status = N'($urandom);
      if ($urandom % 100 == 0) src_enable = N'($urandom);
      wake_evt = ($urandom % 40 == 0);
      if ($urandom % 150 == 0) begin
        logic [31:0] d;
        d = '0;
        d[31:24] = 8'($urandom % 6);
        d[14] = ($urandom % 4 == 0);
        d[8]  = ($urandom % 4 != 0);
        d[4]  = 1'($urandom);
        d[0]  = 1'($urandom);
        d[3:1] = 3'($urandom);
        wr(d, "random R1 R2 R3 R5 R6 R7");
      end else begin
        step(1, "random R3 R4 R8 R9 R10 R11 R12");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule